// File: doc/BRIEF.md
# Program/Erase Completion Status Generator

This block forms the byte a memory device places on its data bus while an internal program or erase operation runs, and drives the shared ready/busy line. A host can learn that the operation has finished in three ways. It can watch the polled bit, which reads opposite to the true value until the operation ends. It can watch the toggle bit, which flips on every fresh read access. It can watch the open-drain busy line.

The inputs are a busy flag, an erase/program qualifier, and a flag that marks the read address as the last loaded one. The block also takes the last loaded byte, the true stored byte from the array, and active-low chip-enable and output-enable strobes that are sampled on the clock. An access is active while both strobes are low. A new access begins on the first clock edge that samples both strobes low after an edge that saw either one high. The toggle state starts at 0 after reset. A host must not rely on its phase at the start of an operation, only on whether it changes.

Top module: `pe_status_gen`

## Requirements
- R1: While `rst_n` is low, `dout` is 0, `dout_en` is 0 and `rb_pull` is 0. After reset the toggle state is 0.
- R2: During a program (`busy`=1, `erase_op`=0) with `addr_hit`=1, `dout[7]` is the complement of `last_byte[7]`.
- R3: During a program with `addr_hit`=0, `dout[7]` equals `array_data[7]`.
- R4: During an erase (`busy`=1, `erase_op`=1), `dout[7]` reads 0 for any address.
- R5: While busy, `dout[6]` shows the toggle state. The toggle state inverts at the clock edge that starts a new access, and the new value is visible from the cycle after that edge.
- R6: Raising and lowering chip-enable alone, output-enable alone, or both together each count as a new access for R5.
- R7: An access held active over several cycles flips the toggle state only once.
- R8: When `busy` is 0, an active access returns `array_data` on all bits. Accesses made while idle leave the toggle state unchanged.
- R9: While busy, `dout[5:0]` equals `array_data[5:0]`.
- R10: When no access is active, `dout` is 0 and `dout_en` is 0. During an access `dout_en` is 1.
- R11: `rb_pull` (1 = pull the shared line low) equals `busy` whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal program or erase running |
| erase_op | input | 1 | 1 = the running operation is an erase |
| addr_hit | input | 1 | Read address equals the last loaded address |
| last_byte | input | W | Last loaded data byte |
| array_data | input | W | True stored data at the read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | W | Read data byte |
| dout_en | output | 1 | Data bus drive enable |
| rb_pull | output | 1 | 1 = pull the open-drain ready/busy line low |

## Verification
Random stimulus mixes program, erase and idle states with address hits and misses and random bytes. This separates the complemented poll bit from the stored bit and from the forced erase value. Each access is started through a different strobe (chip-enable, output-enable, or both), so a design that counts only one strobe produces a toggle phase the model does not predict. Directed cases hold an access over several cycles to catch repeated flipping, and read while idle to show that the toggle state is frozen and the true data returns.

// File: rtl/pe_status_gen.sv
module pe_status_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         erase_op,
  input  logic         addr_hit,
  input  logic [W-1:0] last_byte,
  input  logic [W-1:0] array_data,
  input  logic         ce_n,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic         rb_pull
);
  localparam int PB = W - 1;
  localparam int TB = W - 2;

  logic acc, prev_idle, tgl, poll;
  logic [W-1:0] status;

  assign acc = rst_n & ~ce_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_idle <= 1'b1;
      tgl       <= 1'b0;
    end else begin
      prev_idle <= ~acc;
      if (busy && acc && prev_idle) tgl <= ~tgl;
    end

  always_comb begin
    if (erase_op)      poll = 1'b0;
    else if (addr_hit) poll = ~last_byte[PB];
    else               poll = array_data[PB];
    status     = array_data;
    status[PB] = poll;
    status[TB] = tgl;
  end

  assign dout    = !acc ? '0 : (busy ? status : array_data);
  assign dout_en = acc;
  assign rb_pull = rst_n & busy;
endmodule

module pe_status_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         erase_op,
  input logic         addr_hit,
  input logic [W-1:0] last_byte,
  input logic [W-1:0] array_data,
  input logic         ce_n,
  input logic         oe_n,
  input logic [W-1:0] dout
);
  logic seen;
  logic on;
  assign on = ~ce_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R2
  poll_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_op && addr_hit && on) |-> dout[W-1] == ~last_byte[W-1]);
  // R4
  poll_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_op && on) |-> dout[W-1] == 1'b0);
  // R8
  idle_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && on) |-> dout == array_data);
  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> dout == '0);
  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && busy && on && !$past(on)) |=> (!(busy && on) || dout[W-2] != $past(dout[W-2])));
endmodule

bind pe_status_gen pe_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .erase_op(erase_op), .addr_hit(addr_hit),
  .last_byte(last_byte), .array_data(array_data), .ce_n(ce_n), .oe_n(oe_n), .dout(dout)
);

// File: tb/pe_status_gen_test.sv
module pe_status_gen_test;
  logic clk = 0, rst_n = 0;
  logic busy = 0, erase_op = 0, addr_hit = 0, ce_n = 1, oe_n = 1;
  logic [7:0] last_byte = 0, array_data = 0;
  logic [7:0] dout;
  logic dout_en, rb_pull;
  int errs = 0, checks = 0;
  bit tgl_m = 0;

  always #2 clk = ~clk;

  pe_status_gen #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .erase_op(erase_op), .addr_hit(addr_hit),
    .last_byte(last_byte), .array_data(array_data), .ce_n(ce_n), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en), .rb_pull(rb_pull)
  );

  function automatic logic [7:0] expect_byte(bit b, bit e, bit h, logic [7:0] lb,
                                             logic [7:0] ad, bit t);
    logic [7:0] r;
    r = ad;
    if (b) begin
      r[6] = t;
      r[7] = e ? 1'b0 : (h ? ~lb[7] : ad[7]);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 = chip-enable only, 1 = output-enable only, 2 = both
  task automatic access(int kind, string req);
    @(negedge clk);
    if (kind != 1) ce_n = 1;
    if (kind != 0) oe_n = 1;
    @(negedge clk);
    chk("R10 idle bus", {dout_en, dout}, 9'h0);
    ce_n = 0; oe_n = 0;
    @(posedge clk);
    if (busy) tgl_m = ~tgl_m;
    @(negedge clk);
    chk(req, dout, expect_byte(busy, erase_op, addr_hit, last_byte, array_data, tgl_m));
    chk("R10 drive", dout_en, 1'b1);
    chk("R11 busy line", rb_pull, busy);
  endtask

  initial begin
    #(4 * 200000);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    busy = 1; ce_n = 0; oe_n = 0; array_data = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rb_pull, dout_en, dout}, 10'h0);
    busy = 0; ce_n = 1; oe_n = 1;
    @(negedge clk); rst_n = 1;

    // R1: first busy access after reset reads toggle 1 (flipped from 0)
    busy = 1; erase_op = 0; addr_hit = 1; last_byte = 8'h3C; array_data = 8'h00;
    access(2, "R1 R2 first toggle");
    chk("R1 toggle start", dout[6], 1'b1);
    // R2 poll complement
    chk("R2 poll", dout[7], 1'b1);
    // R7: held access does not flip
    repeat (3) @(negedge clk);
    chk("R7 held", dout[6], tgl_m);
    // R6: each strobe style flips
    access(0, "R6 ce only");
    chk("R6 ce flip", dout[6], 1'b0);
    access(1, "R6 oe only");
    chk("R6 oe flip", dout[6], 1'b1);
    // R3 miss
    addr_hit = 0; array_data = 8'h80;
    access(2, "R3 miss");
    chk("R3 stored bit", dout[7], 1'b1);
    // R4 erase
    erase_op = 1; addr_hit = 1; last_byte = 8'h00; array_data = 8'hFF;
    access(0, "R4 erase");
    chk("R4 poll zero", dout[7], 1'b0);
    // R9 low bits
    chk("R9 low bits", dout[5:0], 6'h3F);
    // R8: idle true data and frozen toggle
    busy = 0; erase_op = 0; array_data = 8'h4E;
    access(1, "R8 idle data");
    access(2, "R8 idle again");
    busy = 1; array_data = 8'h00; addr_hit = 0;
    access(2, "R8 R5 toggle frozen while idle");

    for (int i = 0; i < 80; i++) begin
      busy = $urandom_range(0, 3) != 0;
      erase_op = $urandom_range(0, 1);
      addr_hit = $urandom_range(0, 1);
      last_byte = 8'($urandom);
      array_data = 8'($urandom);
      access($urandom_range(0, 2), "R5 R2 R3 R4 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule